// File: doc/BRIEF.md
# Boot-Mode Chip-Select Decoder

This block turns the upper bits of a 32-bit address into eight expansion chip selects. It also converts a 2-bit bus-width field, taken from a configuration register, into a transfer-mode code for the selected region. Four of the selects are active-low and four are active-high. All selects return to their inactive levels when the address strobe is low or the address lies in the upper half of the space.

A strap input is sampled once when the power-on reset is released. If the strap is high, the block enters test-boot mode, which changes two things:
- The region-to-select map is reversed, so the lowest region drives the last select. Boot fetches then come from a device on select 7.
- Bit 1 of the bus-width field is inverted, so that a field of zero means an 8-bit device.

The mode then holds until the next power-on reset.

A separate isolation path lowers the global output-enable without waiting for a clock. It does this when both test pins are low and the clock-latched user reset is low. The isolation path does not change any internal state.

Top module: `boot_cs_decoder`

## Requirements
- R1: The mode bit is captured from `strap_i` on the first rising clock edge after `rst_ni` goes high; 1 = test-boot, 0 = normal. Later changes of `strap_i` have no effect until `rst_ni` is asserted again. `rst_ni` low forces normal mode.
- R2: In normal mode, with `addr_valid_i` high and `addr_i[31]` = 0, region n = `addr_i[30:28]` activates select n, and only select n.
- R3: In test-boot mode, with `addr_valid_i` high and `addr_i[31]` = 0, region n activates select 7-n, and only that select.
- R4: Selects `cs_o[3:0]` are active-low and `cs_o[7:4]` are active-high, so the all-inactive value of `cs_o` is 8'h0F. At most one select is active at a time.
- R5: When `addr_valid_i` is low, or `addr_i[31]` is 1, `cs_o` equals 8'h0F.
- R6: `xfer_o` encodes 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = PC Card. In normal mode, `width_i` maps 00→32-bit, 01→16-bit, 10→8-bit, 11→PC Card.
- R7: In test-boot mode, `width_i` maps 00→8-bit, 01→PC Card, 10→32-bit, 11→16-bit.
- R8: `oe_o` is 0 combinationally, with no clock edge, whenever `test_ni` = 2'b00 and the latched user reset is 0. In every other case `oe_o` is 1.
- R9: `user_rst_ni` is latched on the rising clock edge, and the latch resets to 1. A change of `user_rst_ni` reaches `oe_o` only after that edge. Entering or leaving isolation leaves `cs_o`, `xfer_o` and the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active-low, asynchronous |
| strap_i | input | 1 | Boot-mode strap, sampled after power-on reset |
| addr_i | input | 32 | Bus address |
| addr_valid_i | input | 1 | Address strobe |
| width_i | input | 2 | Bus-width field from the configuration register |
| test_ni | input | 2 | Test pins; both low requests isolation |
| user_rst_ni | input | 1 | User reset, active-low |
| cs_o | output | 8 | Chip selects; [3:0] active-low, [7:4] active-high |
| xfer_o | output | 2 | Decoded transfer mode |
| oe_o | output | 1 | Global output-enable |

## Verification
The bench builds the block with its defaults: a 32-bit address, 3 region bits and 4 active-low selects. With these values every one of the eight regions can be driven in both modes. The polarity boundary between select 3 and select 4 is also exercised.

Two power-on sequences are run, one with the strap low and one with it high. Between them they give all four width codes in each mode. The isolation checks are sampled between clock edges, which shows that `oe_o` drops with no clock edge. They also show that a raw change of the user reset does not reach `oe_o` before the next edge.

// File: rtl/boot_cs_pkg.sv
package boot_cs_pkg;
  typedef enum logic [1:0] {
    XFER_8    = 2'd0,
    XFER_16   = 2'd1,
    XFER_32   = 2'd2,
    XFER_CARD = 2'd3
  } xfer_e;

  // decode after the mode-dependent inversion of bit 1
  function automatic xfer_e eff_width_map(logic [1:0] eff);
    unique case (eff)
      2'b00:   return XFER_32;
      2'b01:   return XFER_16;
      2'b10:   return XFER_8;
      default: return XFER_CARD;
    endcase
  endfunction
endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  output logic test_mode_o
);
  logic armed_q;
  logic mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      mode_q  <= 1'b0;
    end else if (armed_q) begin
      armed_q <= 1'b0;
      mode_q  <= strap_i;
    end
  end

  assign test_mode_o = mode_q;
endmodule

// File: rtl/hiz_ctrl.sv
module hiz_ctrl #(
  parameter int TEST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEST_W-1:0] test_ni,
  input  logic              user_rst_ni,
  output logic              user_rst_q_o,
  output logic              oe_o
);
  logic ures_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ures_q <= 1'b1;
    else         ures_q <= user_rst_ni;
  end

  // combinational: isolation must not wait for a clock
  assign oe_o         = (|test_ni) | ures_q;
  assign user_rst_q_o = ures_q;
endmodule

// File: rtl/cs_region_decode.sv
module cs_region_decode #(
  parameter int ADDR_W  = 32,
  parameter int SEL_W   = 3,
  parameter int NUM_LOW = 4,
  localparam int NUM_CS = 1 << SEL_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_valid_i,
  input  logic              test_mode_i,
  output logic [NUM_CS-1:0] cs_o
);
  logic [SEL_W-1:0]  region;
  logic              live;
  logic [NUM_CS-1:0] hit;

  assign region = addr_i[ADDR_W-2 -: SEL_W];
  assign live   = addr_valid_i & ~addr_i[ADDR_W-1];

  for (genvar n = 0; n < NUM_CS; n++) begin : g_sel
    localparam logic [SEL_W-1:0] FWD = SEL_W'(n);
    localparam logic [SEL_W-1:0] REV = SEL_W'(NUM_CS - 1 - n);
    assign hit[n] = live & (region == (test_mode_i ? REV : FWD));
    if (n < NUM_LOW) begin : g_lo
      assign cs_o[n] = ~hit[n];
    end else begin : g_hi
      assign cs_o[n] = hit[n];
    end
  end
endmodule

// File: rtl/bus_width_decode.sv
module bus_width_decode
  import boot_cs_pkg::*;
(
  input  logic [1:0] width_i,
  input  logic       test_mode_i,
  output xfer_e      xfer_o
);
  logic [1:0] eff;

  assign eff    = {width_i[1] ^ test_mode_i, width_i[0]};
  assign xfer_o = eff_width_map(eff);
endmodule

// File: rtl/boot_cs_decoder.sv
module boot_cs_decoder
  import boot_cs_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SEL_W   = 3,
  parameter int NUM_LOW = 4,
  parameter int TEST_W  = 2,
  localparam int NUM_CS = 1 << SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_valid_i,
  input  logic [1:0]        width_i,
  input  logic [TEST_W-1:0] test_ni,
  input  logic              user_rst_ni,
  output logic [NUM_CS-1:0] cs_o,
  output logic [1:0]        xfer_o,
  output logic              oe_o
);
  logic  test_mode;
  logic  user_rst_q;
  xfer_e xfer;

  boot_strap_latch i_strap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strap_i     (strap_i),
    .test_mode_o (test_mode)
  );

  hiz_ctrl #(.TEST_W(TEST_W)) i_hiz (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .test_ni      (test_ni),
    .user_rst_ni  (user_rst_ni),
    .user_rst_q_o (user_rst_q),
    .oe_o         (oe_o)
  );

  cs_region_decode #(
    .ADDR_W  (ADDR_W),
    .SEL_W   (SEL_W),
    .NUM_LOW (NUM_LOW)
  ) i_region (
    .addr_i       (addr_i),
    .addr_valid_i (addr_valid_i),
    .test_mode_i  (test_mode),
    .cs_o         (cs_o)
  );

  bus_width_decode i_width (
    .width_i     (width_i),
    .test_mode_i (test_mode),
    .xfer_o      (xfer)
  );

  assign xfer_o = xfer;
endmodule

// File: rtl/boot_cs_decoder_chk.sv
module boot_cs_decoder_chk
  import boot_cs_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SEL_W   = 3,
  parameter int NUM_LOW = 4,
  parameter int TEST_W  = 2,
  localparam int NUM_CS = 1 << SEL_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              addr_valid_i,
  input logic [1:0]        width_i,
  input logic [TEST_W-1:0] test_ni,
  input logic [NUM_CS-1:0] cs_o,
  input logic [1:0]        xfer_o,
  input logic              oe_o,
  input logic              test_mode,
  input logic              user_rst_q
);
  localparam logic [NUM_CS-1:0] INACT = NUM_CS'((1 << NUM_LOW) - 1);

  logic [NUM_CS-1:0] active;
  logic [SEL_W-1:0]  region;
  logic              live;
  logic              seen_q;

  assign active = cs_o ^ INACT;
  assign region = addr_i[ADDR_W-2 -: SEL_W];
  assign live   = addr_valid_i & ~addr_i[ADDR_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assert_mode_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |=> $stable(test_mode));

  assert_fwd_map_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !test_mode) |-> active[region]);

  assert_rev_map_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && test_mode) |-> active[NUM_CS-1-int'(region)]);

  assert_single_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(active));

  assert_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live |-> (cs_o == INACT));

  assert_width_norm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_mode && width_i == 2'b00) |-> (xfer_o == XFER_32));

  assert_width_test_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_mode && width_i == 2'b00) |-> (xfer_o == XFER_8));

  assert_hiz_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_ni == '0 && !user_rst_q) |-> !oe_o);

  assert_hiz_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_ni != '0 || user_rst_q) |-> oe_o);
endmodule

bind boot_cs_decoder boot_cs_decoder_chk #(
  .ADDR_W  (ADDR_W),
  .SEL_W   (SEL_W),
  .NUM_LOW (NUM_LOW),
  .TEST_W  (TEST_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .addr_valid_i (addr_valid_i),
  .width_i      (width_i),
  .test_ni      (test_ni),
  .cs_o         (cs_o),
  .xfer_o       (xfer_o),
  .oe_o         (oe_o),
  .test_mode    (test_mode),
  .user_rst_q   (user_rst_q)
);

// File: tb/test_boot_cs_decoder.sv
module test_boot_cs_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic [31:0] addr = '0;
  logic        valid = 1'b0;
  logic [1:0]  width = 2'b00;
  logic [1:0]  test_n = 2'b11;
  logic        urst_n = 1'b1;
  logic [7:0]  cs;
  logic [1:0]  xfer;
  logic        oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit run   = 1'b0;

  // reference state
  logic m_armed, m_test, m_ures;

  always #4 clk = ~clk;

  boot_cs_decoder i_boot_cs_decoder (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .strap_i      (strap),
    .addr_i       (addr),
    .addr_valid_i (valid),
    .width_i      (width),
    .test_ni      (test_n),
    .user_rst_ni  (urst_n),
    .cs_o         (cs),
    .xfer_o       (xfer),
    .oe_o         (oe)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed <= 1'b1; m_test <= 1'b0; m_ures <= 1'b1;
    end else begin
      if (m_armed) m_test <= strap;
      m_armed <= 1'b0;
      m_ures  <= urst_n;
    end
  end

  function automatic logic [7:0] exp_cs(logic [31:0] a, logic v, logic t);
    logic [7:0] r;
    int k;
    r = 8'h0F;
    if (v && !a[31]) begin
      k = int'(a[30:28]);
      if (t) k = 7 - k;
      r[k] = ~r[k];
    end
    return r;
  endfunction

  function automatic logic [1:0] exp_xfer(logic [1:0] w, logic t);
    if (!t) begin
      case (w) 2'd0: return 2'd2; 2'd1: return 2'd1; 2'd2: return 2'd0; default: return 2'd3; endcase
    end else begin
      case (w) 2'd0: return 2'd0; 2'd1: return 2'd3; 2'd2: return 2'd2; default: return 2'd1; endcase
    end
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (run && rst_n) begin
      chk("R2 R3 R4 R5 cs model", 32'(cs), 32'(exp_cs(addr, valid, m_test)));
      chk("R6 R7 xfer model", 32'(xfer), 32'(exp_xfer(width, m_test)));
      chk("R8 R9 oe model", 32'(oe), 32'(!(test_n == 2'b00 && !m_ures)));
    end
  end

  task automatic drive(logic [31:0] a, logic v, logic [1:0] w);
    @(posedge clk); #1;
    addr = a; valid = v; width = w;
    @(negedge clk); #1;
  endtask

  task automatic power_on(logic s);
    run = 1'b0;
    rst_n = 1'b0; strap = s; valid = 1'b0; width = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    chk("R4 R5 reset cs idle", 32'(cs), 32'h0F);
    chk("R1 reset forces normal width map", 32'(xfer), 32'd2);
    chk("R9 reset oe", 32'(oe), 32'd1);
    rst_n = 1'b1;
    @(posedge clk); #1;
    strap = ~s; // later strap changes must be ignored
    run = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // ---- normal mode ----
    power_on(1'b0);
    repeat (4) @(posedge clk);
    for (int n = 0; n < 8; n++) begin
      drive({1'b0, 3'(n), 28'h0123456 + 28'(n)}, 1'b1, 2'b00);
      chk($sformatf("R2 R4 normal region %0d", n), 32'(cs), 32'(exp_cs({1'b0, 3'(n), 28'h0}, 1'b1, 1'b0)));
    end
    drive(32'h0000_0000, 1'b1, 2'b00);
    chk("R1 strap change ignored after capture", 32'(cs), 32'h0E);
    drive(32'h8000_0000, 1'b1, 2'b00);
    chk("R5 addr bit 31 set", 32'(cs), 32'h0F);
    drive(32'h3000_0000, 1'b0, 2'b00);
    chk("R5 strobe low", 32'(cs), 32'h0F);
    for (int w = 0; w < 4; w++) begin
      drive(32'h1000_0000, 1'b1, 2'(w));
      chk($sformatf("R6 normal width %0d", w), 32'(xfer), 32'(exp_xfer(2'(w), 1'b0)));
    end

    // ---- test-boot mode ----
    power_on(1'b1);
    for (int n = 0; n < 8; n++) begin
      drive({1'b0, 3'(n), 28'hFFF_FFFF}, 1'b1, 2'b00);
      chk($sformatf("R3 R4 test region %0d", n), 32'(cs), 32'(exp_cs({1'b0, 3'(n), 28'h0}, 1'b1, 1'b1)));
    end
    drive(32'h0000_0000, 1'b1, 2'b00);
    chk("R3 boot fetch on select 7", 32'(cs), 32'h8F);
    chk("R7 boot width 8-bit", 32'(xfer), 32'd0);
    for (int w = 0; w < 4; w++) begin
      drive(32'h2000_0000, 1'b1, 2'(w));
      chk($sformatf("R7 test width %0d", w), 32'(xfer), 32'(exp_xfer(2'(w), 1'b1)));
    end

    // ---- isolation ----
    drive(32'h6000_0000, 1'b1, 2'b11);
    test_n = 2'b00; #1;
    chk("R8 pins low, user reset high keeps oe", 32'(oe), 32'd1);
    urst_n = 1'b0; #1;
    chk("R9 raw user reset not yet latched", 32'(oe), 32'd1);
    @(posedge clk); #1;
    test_n = 2'b01; #1;
    chk("R8 one pin high keeps oe", 32'(oe), 32'd1);
    test_n = 2'b00; #1;
    chk("R8 oe drops without clock edge", 32'(oe), 32'd0);
    chk("R9 cs unchanged in isolation", 32'(cs), 32'h0F ^ 32'h02);
    chk("R9 xfer unchanged in isolation", 32'(xfer), 32'd1);
    urst_n = 1'b1; #1;
    chk("R9 release waits for clock", 32'(oe), 32'd0);
    @(posedge clk); #1;
    chk("R8 oe returns after latch", 32'(oe), 32'd1);
    test_n = 2'b11;
    drive(32'h0000_0000, 1'b1, 2'b00);
    chk("R9 mode kept after isolation", 32'(cs), 32'h8F);

    run = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule